// File: doc/BRIEF.md
# Audio Stream Descriptor Control Register

This block holds the register state for one DMA audio stream descriptor and runs its software reset handshake. Software reaches it through a single-cycle write port and a combinational read port. The block holds these fields:

- a control word
- a link position counter
- a cyclic buffer length
- a last valid index
- a format word
- the two 32-bit halves of the descriptor-list base address

Inside the control word, bit 0 is the stream reset flag, bit 1 is the run flag and bits 23:20 carry the stream number.

Entering reset clears the descriptor state, and the reset flag then reads back as 1. From then on the flag is sticky: every write is dropped until software writes the control word with bit 0 cleared. When the run flag changes, the block emits registered start or stop pulses that carry the stream number and a direction flag, for the downstream codec logic. A stop also pulses a request to clear the descriptor-list state. Every accepted control write raises a one-cycle request to re-evaluate the interrupt line. The register port has no back-pressure, and a write always completes in the cycle it is presented.

Top module: `sd_stream_desc`

## Requirements
- R1: After the active-low asynchronous reset, the control word reads 0x2000_0000, which is only the FIFO-ready flag at bit 29. Every other field reads 0, and all pulse outputs are low.
- R2: While the reset flag is 0, writes store at these addresses: 0 control, 1 link position, 2 cyclic buffer length, 3 last valid index (8 bits), 4 format (16 bits), 5 base low, 6 base high. Narrow fields keep only their low bits. Bit 29 of the control word always reads 1. Unmapped addresses read 0.
- R3: Writing the control word with bit 0 set while the reset flag is 0 makes the control word read 0x2000_0001 from the next cycle. The same write zeroes the link position, buffer length, last valid index, format and both base halves.
- R4: While the reset flag is 1, a control write with bit 0 set leaves the control word unchanged and raises no pulse. Writes to any other address are dropped.
- R5: While the reset flag is 1, a control write with bit 0 clear is accepted. The control word then takes the written value, and the other fields become writable again.
- R6: A control write that changes bit 1 from 0 to 1 outside reset gives a start pulse in the cycle after the write. The pulse carries the written bits 23:20 on the stream tag. Rewriting bit 1 as 1 gives no start pulse.
- R7: A control write that changes bit 1 from 1 to 0 gives a stop pulse and a descriptor-clear pulse together, one cycle after the write, tagged with the written bits 23:20.
- R8: Entering reset while bit 1 was 1 gives a stop pulse and a descriptor-clear pulse tagged with the previous bits 23:20. It gives no start pulse.
- R9: Each accepted control write raises the interrupt-update output for one cycle after the write. Ignored control writes and writes to other addresses do not raise it.
- R10: The direction output is 1 exactly when the STREAM_IDX parameter is 4 or more.
- R11: Start, stop, clear and interrupt-update outputs are single-cycle pulses. Start and stop are never high together, and clear never appears without stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data, zero-extended |
| start_pulse | output | 1 | Stream start event |
| stop_pulse | output | 1 | Stream stop event |
| stream_tag | output | 4 | Stream number carried by an event |
| is_output | output | 1 | Direction of this stream |
| desc_clr_pulse | output | 1 | Request to clear descriptor-list state |
| irq_update | output | 1 | Request to recompute the interrupt line |

## Verification
A wrong value held in the reset flag appears at the ports in one of two ways. Writes that should stick are dropped on readback in the next cycle, or writes that should be dropped show up in a field. A wrong held run flag shows up in the cycle after the next control write, as a missing or spurious start or stop pulse. A stale stream number shows up on stream_tag in that same cycle. An entry into reset that leaves stale fields behind is caught by reading every field in the cycle right after the entering write.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int SNUM_W   = 4;
  localparam int SNUM_LSB = 20;
  localparam int B_SRST   = 0;
  localparam int B_RUN    = 1;
  localparam logic [DATA_W-1:0] CTL_FIFO_RDY = 32'h2000_0000;

  localparam logic [ADDR_W-1:0] A_CTL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_LPOS   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CBL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_LVI    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FMT    = 3'd4;
  localparam logic [ADDR_W-1:0] A_BASELO = 3'd5;
  localparam logic [ADDR_W-1:0] A_BASEHI = 3'd6;

  typedef struct packed {
    logic              start;
    logic              stop;
    logic              clr;
    logic              irq;
    logic [SNUM_W-1:0] snum;
  } sd_evt_t;
endpackage

// File: rtl/sd_ctl_unit.sv
module sd_ctl_unit
  import sd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] ctl_q,
  output logic              in_reset,
  output logic              enter_rst,
  output sd_evt_t           evt
);
  logic [DATA_W-1:0] ctl_d;
  logic old_srst, old_run, new_srst, new_run;

  assign old_srst = ctl_q[B_SRST];
  assign old_run  = ctl_q[B_RUN];
  assign new_srst = wr_word[B_SRST];
  assign new_run  = wr_word[B_RUN];
  assign in_reset = old_srst;

  always_comb begin
    ctl_d     = ctl_q;
    evt       = '0;
    enter_rst = 1'b0;
    if (wr_ctl && !(old_srst && new_srst)) begin
      evt.irq = 1'b1;
      if (new_srst) begin
        // reset dominates any run change carried by the same write
        enter_rst = 1'b1;
        ctl_d     = CTL_FIFO_RDY | 32'h1;
        if (old_run) begin
          evt.stop = 1'b1;
          evt.clr  = 1'b1;
          evt.snum = ctl_q[SNUM_LSB +: SNUM_W];
        end
      end else begin
        ctl_d = wr_word | CTL_FIFO_RDY;
        if (new_run && !old_run) begin
          evt.start = 1'b1;
          evt.snum  = wr_word[SNUM_LSB +: SNUM_W];
        end else if (!new_run && old_run) begin
          evt.stop = 1'b1;
          evt.clr  = 1'b1;
          evt.snum = wr_word[SNUM_LSB +: SNUM_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_FIFO_RDY;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/sd_field_reg.sv
module sd_field_reg
  import sd_pkg::*;
#(
  parameter int              W    = 32,
  parameter logic [ADDR_W-1:0] ADDR = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_bits,
  input  logic              hold,
  input  logic              clear,
  output logic [W-1:0]      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 q <= '0;
    else if (clear)                             q <= '0;
    else if (wr_en && !hold && wr_addr == ADDR) q <= wr_bits;
  end
endmodule

// File: rtl/sd_evt_reg.sv
module sd_evt_reg
  import sd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sd_evt_t           evt_d,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              clr_pulse,
  output logic              irq_pulse,
  output logic [SNUM_W-1:0] tag
);
  sd_evt_t evt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
  assign start_pulse = evt_q.start;
  assign stop_pulse  = evt_q.stop;
  assign clr_pulse   = evt_q.clr;
  assign irq_pulse   = evt_q.irq;
  assign tag         = evt_q.snum;
endmodule

// File: rtl/sd_stream_desc.sv
module sd_stream_desc
  import sd_pkg::*;
#(
  parameter int STREAM_IDX = 5,
  parameter int OUT_BASE   = 4,
  parameter int LPOS_W     = 32,
  parameter int CBL_W      = 32,
  parameter int LVI_W      = 8,
  parameter int FMT_W      = 16,
  parameter int BASE_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        start_pulse,
  output logic        stop_pulse,
  output logic [3:0]  stream_tag,
  output logic        is_output,
  output logic        desc_clr_pulse,
  output logic        irq_update
);
  localparam bit IS_OUT = (STREAM_IDX >= OUT_BASE);

  logic [DATA_W-1:0] ctl_q;
  logic              in_reset, enter_rst, wr_ctl;
  sd_evt_t           evt;
  logic [LPOS_W-1:0] lpos_q;
  logic [CBL_W-1:0]  cbl_q;
  logic [LVI_W-1:0]  lvi_q;
  logic [FMT_W-1:0]  fmt_q;
  logic [BASE_W-1:0] baselo_q, basehi_q;

  assign wr_ctl = wr_en && (wr_addr == A_CTL);

  sd_ctl_unit u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_word(wr_data),
    .ctl_q(ctl_q), .in_reset(in_reset), .enter_rst(enter_rst), .evt(evt)
  );

  sd_field_reg #(.W(LPOS_W), .ADDR(A_LPOS)) u_lpos (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[LPOS_W-1:0]), .hold(in_reset), .clear(enter_rst), .q(lpos_q));
  sd_field_reg #(.W(CBL_W), .ADDR(A_CBL)) u_cbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[CBL_W-1:0]), .hold(in_reset), .clear(enter_rst), .q(cbl_q));
  sd_field_reg #(.W(LVI_W), .ADDR(A_LVI)) u_lvi (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[LVI_W-1:0]), .hold(in_reset), .clear(enter_rst), .q(lvi_q));
  sd_field_reg #(.W(FMT_W), .ADDR(A_FMT)) u_fmt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[FMT_W-1:0]), .hold(in_reset), .clear(enter_rst), .q(fmt_q));
  sd_field_reg #(.W(BASE_W), .ADDR(A_BASELO)) u_baselo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[BASE_W-1:0]), .hold(in_reset), .clear(enter_rst), .q(baselo_q));
  sd_field_reg #(.W(BASE_W), .ADDR(A_BASEHI)) u_basehi (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[BASE_W-1:0]), .hold(in_reset), .clear(enter_rst), .q(basehi_q));

  sd_evt_reg u_evt (
    .clk(clk), .rst_n(rst_n), .evt_d(evt),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .clr_pulse(desc_clr_pulse),
    .irq_pulse(irq_update), .tag(stream_tag));

  assign is_output = IS_OUT;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTL:    rd_data = ctl_q;
      A_LPOS:   rd_data[LPOS_W-1:0] = lpos_q;
      A_CBL:    rd_data[CBL_W-1:0]  = cbl_q;
      A_LVI:    rd_data[LVI_W-1:0]  = lvi_q;
      A_FMT:    rd_data[FMT_W-1:0]  = fmt_q;
      A_BASELO: rd_data[BASE_W-1:0] = baselo_q;
      A_BASEHI: rd_data[BASE_W-1:0] = basehi_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sd_stream_desc_chk.sv
module sd_stream_desc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [31:0] ctl_q,
  input logic [31:0] lpos_q,
  input logic [31:0] cbl_q,
  input logic        start_pulse,
  input logic        stop_pulse,
  input logic        desc_clr_pulse,
  input logic        irq_update
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_addr == 3'd0);

  p_enter_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_q[0] && wr_data[0]) |=> (ctl_q == 32'h2000_0001 && lpos_q == 0 && cbl_q == 0));

  p_sticky_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_q[0] && wr_data[0]) |=> ($stable(ctl_q) && !irq_update && !start_pulse && !stop_pulse));

  p_fields_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |=> ($stable(lpos_q) && $stable(cbl_q)));

  p_start_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> (ctl_q[1] && $past(!ctl_q[1])));

  p_clr_with_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_clr_pulse |-> stop_pulse);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update |-> $past(ctl_wr));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));

  p_single_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_update && !$past(ctl_wr, 1)) |-> 1'b0);
endmodule

bind sd_stream_desc sd_stream_desc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctl_q(ctl_q), .lpos_q(32'(lpos_q)), .cbl_q(32'(cbl_q)),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .desc_clr_pulse(desc_clr_pulse), .irq_update(irq_update)
);

// File: tb/sd_stream_desc_test.sv
module sd_stream_desc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        start_pulse, stop_pulse, is_output, desc_clr_pulse, irq_update;
  logic [3:0]  stream_tag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // pulses captured in the cycle after a write
  logic c_start, c_stop, c_clr, c_irq;
  logic [3:0] c_tag;

  sd_stream_desc uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .stream_tag(stream_tag), .is_output(is_output), .desc_clr_pulse(desc_clr_pulse),
    .irq_update(irq_update));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c_start = start_pulse; c_stop = stop_pulse; c_clr = desc_clr_pulse;
    c_irq = irq_update; c_tag = stream_tag;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic quiet_chk(input string req);
    @(negedge clk);
    chk(req, {28'd0, start_pulse, stop_pulse, desc_clr_pulse, irq_update}, 32'd0);
  endtask

  task automatic t_reset_state;
    rd_chk("R1 ctl", 3'd0, 32'h2000_0000);
    for (int a = 1; a < 8; a++) rd_chk("R1 field", 3'(a), 32'd0);
    chk("R1 pulses", {28'd0, start_pulse, stop_pulse, desc_clr_pulse, irq_update}, 32'd0);
  endtask

  task automatic t_fields;
    wr(3'd1, 32'hDEAD_BEEF); chk("R9 non-ctl write no irq", {31'd0, c_irq}, 32'd0);
    wr(3'd2, 32'h0001_0000);
    wr(3'd3, 32'h1234_56A7);
    wr(3'd4, 32'hFFFF_4011);
    wr(3'd5, 32'hCAFE_0080);
    wr(3'd6, 32'h0000_00FF);
    wr(3'd7, 32'h5555_5555);
    rd_chk("R2 lpos", 3'd1, 32'hDEAD_BEEF);
    rd_chk("R2 cbl", 3'd2, 32'h0001_0000);
    rd_chk("R2 lvi", 3'd3, 32'h0000_00A7);
    rd_chk("R2 fmt", 3'd4, 32'h0000_4011);
    rd_chk("R2 baselo", 3'd5, 32'hCAFE_0080);
    rd_chk("R2 basehi", 3'd6, 32'h0000_00FF);
    rd_chk("R2 unmapped", 3'd7, 32'd0);
  endtask

  task automatic t_start;
    wr(3'd0, 32'h0030_0002);
    chk("R6 start", {31'd0, c_start}, 32'd1);
    chk("R6 tag", {28'd0, c_tag}, 32'd3);
    chk("R11 no stop with start", {30'd0, c_stop, c_clr}, 32'd0);
    chk("R9 irq", {31'd0, c_irq}, 32'd1);
    chk("R10 direction", {31'd0, is_output}, 32'd1);
    rd_chk("R2 ctl readback", 3'd0, 32'h2030_0002);
    quiet_chk("R11 single cycle");
    wr(3'd0, 32'h0090_0002);
    chk("R6 no restart", {31'd0, c_start}, 32'd0);
    chk("R9 irq on rewrite", {31'd0, c_irq}, 32'd1);
  endtask

  task automatic t_stop;
    wr(3'd0, 32'h0040_0000);
    chk("R7 stop+clr", {30'd0, c_stop, c_clr}, 32'd3);
    chk("R7 tag", {28'd0, c_tag}, 32'd4);
    chk("R7 no start", {31'd0, c_start}, 32'd0);
    quiet_chk("R11 single cycle stop");
  endtask

  task automatic t_enter_reset;
    wr(3'd1, 32'h0000_1111);
    wr(3'd4, 32'h0000_2222);
    wr(3'd0, 32'h0050_0001);
    chk("R3 irq", {31'd0, c_irq}, 32'd1);
    chk("R3 no events", {29'd0, c_start, c_stop, c_clr}, 32'd0);
    rd_chk("R3 ctl", 3'd0, 32'h2000_0001);
    for (int a = 1; a < 7; a++) rd_chk("R3 cleared", 3'(a), 32'd0);
  endtask

  task automatic t_sticky;
    wr(3'd0, 32'h00F0_0003);
    chk("R4 ignored no irq", {31'd0, c_irq}, 32'd0);
    chk("R4 ignored no start", {31'd0, c_start}, 32'd0);
    rd_chk("R4 ctl kept", 3'd0, 32'h2000_0001);
    wr(3'd1, 32'h0000_1234);
    rd_chk("R4 field dropped", 3'd1, 32'd0);
    wr(3'd6, 32'h0000_0077);
    rd_chk("R4 base dropped", 3'd6, 32'd0);
  endtask

  task automatic t_exit;
    wr(3'd0, 32'h0000_0000);
    chk("R5 irq on exit", {31'd0, c_irq}, 32'd1);
    rd_chk("R5 ctl", 3'd0, 32'h2000_0000);
    wr(3'd1, 32'h0000_1234);
    rd_chk("R5 field writable", 3'd1, 32'h0000_1234);
  endtask

  task automatic t_reset_while_run;
    wr(3'd0, 32'h0070_0002);
    chk("R6 start tag 7", {28'd0, c_tag}, 32'd7);
    wr(3'd0, 32'h0020_0003);
    chk("R8 stop+clr", {30'd0, c_stop, c_clr}, 32'd3);
    chk("R8 prior tag", {28'd0, c_tag}, 32'd7);
    chk("R8 no start", {31'd0, c_start}, 32'd0);
    rd_chk("R8 ctl", 3'd0, 32'h2000_0001);
    rd_chk("R8 lpos cleared", 3'd1, 32'd0);
    wr(3'd0, 32'h0000_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fields();
    t_start();
    t_stop();
    t_enter_reset();
    t_sticky();
    t_exit();
    t_reset_while_run();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule